// File: doc/BRIEF.md
# Table-Driven Character Display Refresh Engine

This block rebuilds the contents of a 32-position character display from two local memories. One is a 256 x 8 character store. The other is a 32 x 36 region table. Each valid table row describes one run of characters. A row gives the first display slot, the run length, the stepping direction, the first character address and a wrap window in character memory. The window is set by a base address and by a window length counted from the start address.

A host loads both memories through synchronous write ports. Those ports stay open while the engine runs. A 2-bit command starts work. A clear fills the character store with blanks. A refresh walks the whole table and emits one (slot, character) pair per cycle on a display-write strobe. A busy flag covers the full run of either command, and no new command is taken while it is high.

Top module: `lcd_table_refresh`

## Requirements
- R1: Command codes: 2'b01 starts a clear and 2'b10 starts a refresh. 2'b00 and 2'b11 have no effect: busy stays low and the display port stays silent.
- R2: A clear writes 8'h20 to all 256 character locations over exactly 256 busy cycles and produces no display writes. The blanks only reach the display through a later refresh.
- R3: Each table row is laid out as bit 35 valid, bit 31 direction, bits 30:26 first slot, bits 25:21 run length minus one, bits 20:13 wrap base, bits 12:5 first address and bits 4:0 window length minus one. Bits 34:32 are unused. After reset, row 0 holds 36'h883E0001F and every other row has bit 35 clear.
- R4: A refresh visits rows 0 to 31 in ascending order and skips rows whose valid bit is 0.
- R5: A valid row produces exactly run length plus one display writes.
- R6: With direction 1 the slot counts up, and 31 is followed by 0. With direction 0 it counts down, and 0 is followed by 31.
- R7: The character address starts at the first address. When it equals (first address + window field) mod 256, the next address is the wrap base. Otherwise it advances by one, and 255 is followed by 0.
- R8: Busy is high from the cycle after a command is taken until the command completes, and display writes occur only while busy is high. Commands presented while busy is high are ignored. A refresh of the reset table keeps busy high for 64 cycles.
- R9: Host writes to either memory are accepted during a refresh. A row or character written before the engine reaches it is used by that same refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 2 | Command code, sampled while idle |
| busy | output | 1 | High while a command runs |
| chr_we | input | 1 | Character memory write enable |
| chr_waddr | input | 8 | Character memory write address |
| chr_wdata | input | 8 | Character memory write data |
| tbl_we | input | 1 | Region table write enable |
| tbl_waddr | input | 5 | Region table row index |
| tbl_wdata | input | 36 | Region table row data |
| disp_we | output | 1 | Display write strobe |
| disp_pos | output | 5 | Display slot for the current write |
| disp_char | output | 8 | Character for the current write |

## Verification
The hardest case to reach is a host write that lands during a refresh and must still be seen by that same refresh. The bench starts a refresh and, within its first cycles, rewrites a row far down the table and a character that only the last row reads. Both writes then come before the engine gets to them. Address wrap at 255 and slot wrap in both directions are reached through rows whose start address and slot sit next to those limits. A clear pulsed in the middle of a refresh shows that a command during busy is dropped, because a later refresh still returns the old characters.

// File: rtl/lcd_table_refresh.sv
module lcd_table_refresh #(
  parameter int POS_W  = 5,
  parameter int ADDR_W = 8,
  parameter int CHAR_W = 8,
  localparam int ENTRY_W = 3*POS_W + 2*ADDR_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cmd,
  output logic              busy,
  input  logic              chr_we,
  input  logic [ADDR_W-1:0] chr_waddr,
  input  logic [CHAR_W-1:0] chr_wdata,
  input  logic              tbl_we,
  input  logic [POS_W-1:0]  tbl_waddr,
  input  logic [ENTRY_W-1:0] tbl_wdata,
  output logic              disp_we,
  output logic [POS_W-1:0]  disp_pos,
  output logic [CHAR_W-1:0] disp_char
);
  localparam int NROW  = 1 << POS_W;
  localparam int NCHR  = 1 << ADDR_W;
  localparam int WL_LO = 0;
  localparam int SA_LO = POS_W;
  localparam int WB_LO = SA_LO + ADDR_W;
  localparam int LN_LO = WB_LO + ADDR_W;
  localparam int SP_LO = LN_LO + POS_W;
  localparam int DR_B  = SP_LO + POS_W;
  localparam int VL_B  = DR_B + 4;
  localparam logic [CHAR_W-1:0] BLANK = CHAR_W'(32);
  localparam logic [ENTRY_W-1:0] ROW0_INIT =
    (ENTRY_W'(1) << VL_B) | (ENTRY_W'(1) << DR_B) |
    (ENTRY_W'(NROW-1) << LN_LO) | ENTRY_W'(NROW-1);

  typedef enum logic [2:0] {S_IDLE, S_CLR, S_ENT, S_RUN, S_END} st_t;

  st_t st;
  logic [ENTRY_W-1:0] tbl [NROW];
  logic [CHAR_W-1:0]  cmem [NCHR];
  logic [ADDR_W-1:0]  clr_a, rd_a, a_end, a_base;
  logic [POS_W-1:0]   row, pos, left, pipe_pos;
  logic               dir, pipe_v;
  logic [CHAR_W-1:0]  rd_q;
  logic [ENTRY_W-1:0] cur;

  assign cur       = tbl[row];
  assign busy      = (st != S_IDLE);
  assign disp_we   = pipe_v;
  assign disp_pos  = pipe_pos;
  assign disp_char = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NROW; i++) tbl[i] <= (i == 0) ? ROW0_INIT : '0;
    end else if (tbl_we) begin
      tbl[tbl_waddr] <= tbl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_CLR) cmem[clr_a] <= BLANK;
    else if (chr_we) cmem[chr_waddr] <= chr_wdata;
  end

  always_ff @(posedge clk) rd_q <= cmem[rd_a];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      clr_a    <= '0;
      rd_a     <= '0;
      a_end    <= '0;
      a_base   <= '0;
      row      <= '0;
      pos      <= '0;
      left     <= '0;
      dir      <= 1'b0;
      pipe_v   <= 1'b0;
      pipe_pos <= '0;
    end else begin
      pipe_v   <= (st == S_RUN);
      pipe_pos <= pos;
      unique case (st)
        S_IDLE: begin
          if (cmd == 2'b01) begin
            st    <= S_CLR;
            clr_a <= '0;
          end else if (cmd == 2'b10) begin
            st  <= S_ENT;
            row <= '0;
          end
        end
        S_CLR: begin
          clr_a <= clr_a + 1'b1;
          if (clr_a == ADDR_W'(NCHR-1)) st <= S_IDLE;
        end
        S_ENT: begin
          if (cur[VL_B]) begin
            pos    <= cur[SP_LO +: POS_W];
            left   <= cur[LN_LO +: POS_W];
            dir    <= cur[DR_B];
            rd_a   <= cur[SA_LO +: ADDR_W];
            a_base <= cur[WB_LO +: ADDR_W];
            a_end  <= cur[SA_LO +: ADDR_W] + ADDR_W'(cur[WL_LO +: POS_W]);
            st     <= S_RUN;
          end else if (row == POS_W'(NROW-1)) begin
            st <= S_IDLE;
          end else begin
            row <= row + 1'b1;
          end
        end
        S_RUN: begin
          rd_a <= (rd_a == a_end) ? a_base : rd_a + 1'b1;
          pos  <= dir ? pos + 1'b1 : pos - 1'b1;
          left <= left - 1'b1;
          if (left == '0) begin
            if (row == POS_W'(NROW-1)) st <= S_END;
            else begin
              row <= row + 1'b1;
              st  <= S_ENT;
            end
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_table_refresh_chk.sv
module lcd_table_refresh_chk #(
  parameter int ADDR_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd,
  input logic       busy,
  input logic       disp_we
);
  logic              in_clr;
  logic [ADDR_W:0]   clr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_clr <= 1'b0;
      clr_n  <= '0;
    end else begin
      if (!busy && cmd == 2'b01) in_clr <= 1'b1;
      else if (!busy) in_clr <= 1'b0;
      clr_n <= (busy && in_clr) ? clr_n + 1'b1 : '0;
    end
  end

  p_write_needs_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_we |-> busy);
  p_start_on_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cmd == 2'b01 || cmd == 2'b10)) |=> busy);
  p_reserved_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 2'b11) |=> !busy);
  p_none_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd == 2'b00) |=> !busy);
  p_clear_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_clr && busy) |-> !disp_we);
  p_clear_length_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && in_clr) |-> (clr_n == (ADDR_W+1)'(1 << ADDR_W)));
endmodule

bind lcd_table_refresh lcd_table_refresh_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .busy(busy), .disp_we(disp_we)
);

// File: tb/lcd_table_refresh_test.sv
module lcd_table_refresh_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic        busy;
  logic        chr_we = 1'b0;
  logic [7:0]  chr_waddr = '0;
  logic [7:0]  chr_wdata = '0;
  logic        tbl_we = 1'b0;
  logic [4:0]  tbl_waddr = '0;
  logic [35:0] tbl_wdata = '0;
  logic        disp_we;
  logic [4:0]  disp_pos;
  logic [7:0]  disp_char;

  int total = 0;
  int bad = 0;
  logic [7:0]  ref_chr [256];
  logic [35:0] ref_tbl [32];
  logic [4:0]  cap_pos [1024];
  logic [7:0]  cap_chr [1024];
  logic [4:0]  exp_pos [1024];
  logic [7:0]  exp_chr [1024];
  int cap_n = 0;
  int exp_n = 0;

  always #10 clk = ~clk;

  lcd_table_refresh uut (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .busy(busy),
    .chr_we(chr_we), .chr_waddr(chr_waddr), .chr_wdata(chr_wdata),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .disp_we(disp_we), .disp_pos(disp_pos), .disp_char(disp_char)
  );

  always @(negedge clk) begin
    if (disp_we && cap_n < 1024) begin
      cap_pos[cap_n] = disp_pos;
      cap_chr[cap_n] = disp_char;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [35:0] mk_row(bit v, bit d, int sp, int lnm1,
                                         int wb, int sa, int wlm1);
    return {v, 3'b000, d, 5'(sp), 5'(lnm1), 8'(wb), 8'(sa), 5'(wlm1)};
  endfunction

  task automatic build_expect();
    exp_n = 0;
    for (int e = 0; e < 32; e++) begin
      logic [35:0] t;
      logic [7:0] a, ae;
      logic [4:0] p;
      t = ref_tbl[e];
      if (t[35]) begin
        p  = t[30:26];
        a  = t[12:5];
        ae = t[12:5] + 8'(t[4:0]);
        for (int k = 0; k <= int'(t[25:21]); k++) begin
          exp_pos[exp_n] = p;
          exp_chr[exp_n] = ref_chr[a];
          exp_n++;
          a = (a == ae) ? t[20:13] : a + 8'd1;
          p = t[31] ? p + 5'd1 : p - 5'd1;
        end
      end
    end
  endtask

  task automatic compare(input string req);
    check(cap_n == exp_n, req, "write count", cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      check(cap_pos[i] == exp_pos[i], req, $sformatf("slot of write %0d", i),
            cap_pos[i], exp_pos[i]);
      check(cap_chr[i] == exp_chr[i], req, $sformatf("char of write %0d", i),
            cap_chr[i], exp_chr[i]);
    end
  endtask

  task automatic put_chr(input int a, input int d);
    @(negedge clk);
    chr_we = 1'b1; chr_waddr = 8'(a); chr_wdata = 8'(d);
    ref_chr[a] = 8'(d);
    @(negedge clk);
    chr_we = 1'b0;
  endtask

  task automatic put_row(input int r, input logic [35:0] v);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 5'(r); tbl_wdata = v;
    ref_tbl[r] = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic issue(input logic [1:0] c);
    @(negedge clk); cmd = c;
    @(negedge clk); cmd = 2'b00;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check(busy == 1'b0, "R8", "busy after reset", busy, 0);
    check(disp_we == 1'b0, "R8", "display strobe after reset", disp_we, 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      chr_we = 1'b1; chr_waddr = 8'(i); chr_wdata = 8'(i*7 + 3);
      ref_chr[i] = 8'(i*7 + 3);
    end
    @(negedge clk); chr_we = 1'b0;
  endtask

  task automatic t_default_refresh();
    int n;
    cap_n = 0;
    issue(2'b10);
    wait_idle(n);
    check(n == 64, "R8", "busy cycles for reset table", n, 64);
    build_expect();
    check(exp_n == 32, "R3", "model size of reset row 0", exp_n, 32);
    compare("R3");
  endtask

  task automatic t_busy_reject();
    int n;
    cap_n = 0;
    issue(2'b10);
    issue(2'b01);
    wait_idle(n);
    build_expect();
    compare("R8");
    cap_n = 0;
    issue(2'b10);
    wait_idle(n);
    check(cap_chr[5] == ref_chr[5], "R8", "char kept after rejected clear",
          cap_chr[5], ref_chr[5]);
  endtask

  task automatic t_ignored_cmds();
    cap_n = 0;
    issue(2'b11);
    check(busy == 1'b0, "R1", "busy after code 11", busy, 0);
    issue(2'b00);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after code 00", busy, 0);
    check(cap_n == 0, "R1", "writes after ignored codes", cap_n, 0);
  endtask

  task automatic t_clear();
    int n;
    cap_n = 0;
    issue(2'b01);
    wait_idle(n);
    check(n == 256, "R2", "clear busy cycles", n, 256);
    check(cap_n == 0, "R2", "display writes during clear", cap_n, 0);
    for (int i = 0; i < 256; i++) ref_chr[i] = 8'h20;
    cap_n = 0;
    issue(2'b10);
    wait_idle(n);
    build_expect();
    compare("R2");
  endtask

  task automatic t_regions();
    int n;
    t_fill();
    put_row(0, 36'h0);
    put_row(3, mk_row(1, 0, 2, 5, 8'h10, 8'hFE, 3));
    put_row(7, mk_row(1, 1, 30, 3, 8'h80, 8'h80, 0));
    put_row(31, mk_row(1, 1, 5, 0, 8'h00, 8'h40, 0));
    cap_n = 0;
    issue(2'b10);
    wait_idle(n);
    build_expect();
    check(exp_n == 11, "R5", "model write total", exp_n, 11);
    compare("R4");
    check(cap_pos[3] == 5'd31, "R6", "down-count slot after 0", cap_pos[3], 31);
    check(cap_pos[7] == 5'd31 && cap_pos[8] == 5'd0, "R6",
          "up-count slot after 31", cap_pos[8], 0);
    check(cap_chr[2] == ref_chr[8'h00], "R7", "address after 255",
          cap_chr[2], ref_chr[8'h00]);
    check(cap_chr[4] == ref_chr[8'h10], "R7", "address at wrap base",
          cap_chr[4], ref_chr[8'h10]);
  endtask

  task automatic t_live_writes();
    int n;
    cap_n = 0;
    issue(2'b10);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = 5'd20;
    tbl_wdata = mk_row(1, 0, 10, 2, 8'h33, 8'h31, 1);
    ref_tbl[20] = tbl_wdata;
    @(negedge clk);
    tbl_we = 1'b0;
    chr_we = 1'b1; chr_waddr = 8'h40; chr_wdata = 8'hC3;
    ref_chr[8'h40] = 8'hC3;
    @(negedge clk);
    chr_we = 1'b0;
    wait_idle(n);
    build_expect();
    compare("R9");
    check(cap_n > 0 && cap_chr[cap_n-1] == 8'hC3, "R9", "late char update",
          (cap_n > 0) ? cap_chr[cap_n-1] : 0, 8'hC3);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ref_tbl[i] = '0;
    ref_tbl[0] = 36'h883E0001F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_default_refresh();
    t_busy_reject();
    t_ignored_cmds();
    t_clear();
    t_regions();
    t_live_writes();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule